// File: doc/BRIEF.md
# Programmable Sum-of-Products Array

This block is a small two-level logic array whose function is set at run time. Each input is offered to a programmable AND plane in both polarities. The AND plane forms product terms. An OR plane then combines those terms into the outputs. A mode input chooses how the OR plane works. In one mode every term-to-output link is programmable. In the other mode each output combines a fixed, disjoint block of terms.

Every output passes through a macrocell. The macrocell holds the sum in a flip-flop and chooses between the raw sum and the stored value. It also drives an output-enable that an external pad uses to tri-state the pin. The stored value of each macrocell returns to the AND plane as an extra literal, in both polarities.

All programming bits form one serial chain. The chain is loaded one bit per clock while the load input is high.

Top module: `sop_array`

## Requirements
- R1: While `cfg_en_i` is high, each rising clock edge shifts `cfg_bit_i` into position 0 of a 116-bit chain, and every bit moves up by one. Bits are sent from position 115 down to 0. The chain layout is as follows:
  - Literal `l` of term `p` is at `p*12+l`.
  - For `l = 2k`, the literal is source `k` in true form; for `l = 2k+1`, it is source `k` complemented.
  - Sources 0..3 are `in_i[0..3]`; sources 4 and 5 are the feedback of outputs 0 and 1.
  - The link from term `p` to output `o` is at `96+o*8+p`.
  - The register select of output `o` is at `112+2*o`, and its output enable is at `113+2*o`.
- R2: While `cfg_en_i` is low, the chain holds its contents whatever `cfg_bit_i` does.
- R3: A product term is the AND of its connected literals. A term with no connected literal is 0.
- R4: With `pal_mode_i` low, output `o`'s sum is the OR of the terms whose link bit is set. With no link set, the sum is 0.
- R5: With `pal_mode_i` high, output 0 sums terms 0..3 and output 1 sums terms 4..7, and the link bits have no effect.
- R6: Each macrocell flip-flop captures its sum on every rising edge. When the register select bit is 1, `out_o` shows the flip-flop. When it is 0, `out_o` shows the sum in the same cycle.
- R7: `oe_o[o]` equals output `o`'s enable bit. It is forced low while `cfg_en_i` is high.
- R8: The feedback literal of output `o` carries that macrocell's flip-flop value, in both polarities, whichever result `out_o` selects.
- R9: Driving `rst_ni` low clears the chain and the flip-flops at once, so `out_o` and `oe_o` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | 1 | Load enable for the serial programming chain |
| cfg_bit_i | input | 1 | Serial programming data |
| pal_mode_i | input | 1 | 1 = fixed term groups per output, 0 = programmable OR links |
| in_i | input | 4 | Logic inputs |
| out_o | output | 2 | Macrocell results |
| oe_o | output | 2 | Pad drive enables; the pin is high impedance when low |

## Verification
A bit that lands in the wrong chain position changes the function of a specific term or output. That error appears at `out_o` on the first input pattern that exercises the term, or on the first cycle after loading ends if an enable bit is affected. A flip-flop holding a wrong value shows at a registered output on the next cycle. Through feedback, it can also corrupt the other output in that same cycle. The bench compares both outputs with a behavioural model on every clock, across full input sweeps in both OR-plane modes.

// File: rtl/sop_array_pkg.sv
package sop_array_pkg;
  typedef struct packed {
    logic oe;
    logic reg_sel;
  } mc_cfg_t;

  function automatic int lit_count(int n_in, int n_out);
    return 2 * (n_in + n_out);
  endfunction
endpackage

// File: rtl/sop_cfg_chain.sv
module sop_cfg_chain #(
  parameter int W = 116
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= {q_o[W-2:0], bit_i};
  end

  // R1
  cfg_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (q_o[0] == $past(bit_i)) && (q_o[W-1:1] == $past(q_o[W-2:0])));
  // R2
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_o));
endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
  parameter int N_LIT = 12,
  parameter int N_PT  = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_LIT-1:0]      lit_i,
  input  logic [N_PT*N_LIT-1:0] mask_i,
  output logic [N_PT-1:0]       pt_o
);
  for (genvar p = 0; p < N_PT; p++) begin : g_pt
    logic [N_LIT-1:0] m;
    assign m       = mask_i[p*N_LIT +: N_LIT];
    // unconnected literals pass as 1; an empty term is forced to 0
    assign pt_o[p] = (|m) & (&(lit_i | ~m));

    // R3
    empty_term_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (m == '0) |-> !pt_o[p]);
  end
endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
  parameter int N_PT  = 8,
  parameter int N_OUT = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  pal_mode_i,
  input  logic [N_PT-1:0]       pt_i,
  input  logic [N_OUT*N_PT-1:0] conn_i,
  output logic [N_OUT-1:0]      sum_o
);
  localparam int GRP = N_PT / N_OUT;

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [N_PT-1:0] grp_m, sel;
    for (genvar p = 0; p < N_PT; p++) begin : g_grp
      assign grp_m[p] = ((p / GRP) == o) ? 1'b1 : 1'b0;
    end
    assign sel      = pal_mode_i ? grp_m : conn_i[o*N_PT +: N_PT];
    assign sum_o[o] = |(pt_i & sel);

    // R5
    pal_group_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pal_mode_i |-> (sum_o[o] == |pt_i[o*GRP +: GRP]));
  end
endmodule

// File: rtl/sop_macrocell.sv
module sop_macrocell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sum_i,
  input  logic reg_sel_i,
  input  logic oe_cfg_i,
  input  logic load_i,
  output logic out_o,
  output logic oe_o,
  output logic fb_o
);
  logic q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= 1'b0;
    else         q <= sum_i;
  end

  assign out_o = reg_sel_i ? q : sum_i;
  assign oe_o  = oe_cfg_i & ~load_i;
  // feedback always taps the flop so no loop forms in comb mode
  assign fb_o  = q;

  // R6
  reg_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (q == $past(sum_i)));
endmodule

// File: rtl/sop_array.sv
module sop_array
  import sop_array_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_PT  = 8,
  parameter int N_OUT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_en_i,
  input  logic             cfg_bit_i,
  input  logic             pal_mode_i,
  input  logic [N_IN-1:0]  in_i,
  output logic [N_OUT-1:0] out_o,
  output logic [N_OUT-1:0] oe_o
);
  localparam int N_SRC = N_IN + N_OUT;
  localparam int N_LIT = lit_count(N_IN, N_OUT);
  localparam int AND_W = N_PT * N_LIT;
  localparam int OR_W  = N_OUT * N_PT;
  localparam int MC_W  = N_OUT * $bits(mc_cfg_t);
  localparam int CFG_W = AND_W + OR_W + MC_W;

  logic [CFG_W-1:0] cfg;
  logic [N_SRC-1:0] src;
  logic [N_LIT-1:0] lit;
  logic [N_PT-1:0]  pt;
  logic [N_OUT-1:0] sum, fb;
  mc_cfg_t          mc_cfg [N_OUT];

  sop_cfg_chain #(.W(CFG_W)) u_chain (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (cfg_en_i),
    .bit_i (cfg_bit_i),
    .q_o   (cfg)
  );

  assign src = {fb, in_i};
  for (genvar k = 0; k < N_SRC; k++) begin : g_lit
    assign lit[2*k]   = src[k];
    assign lit[2*k+1] = ~src[k];
  end

  sop_and_plane #(.N_LIT(N_LIT), .N_PT(N_PT)) u_and (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lit_i (lit),
    .mask_i(cfg[AND_W-1:0]),
    .pt_o  (pt)
  );

  sop_or_plane #(.N_PT(N_PT), .N_OUT(N_OUT)) u_or (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pal_mode_i(pal_mode_i),
    .pt_i      (pt),
    .conn_i    (cfg[AND_W +: OR_W]),
    .sum_o     (sum)
  );

  for (genvar o = 0; o < N_OUT; o++) begin : g_mc
    assign mc_cfg[o] = mc_cfg_t'(cfg[AND_W + OR_W + o*$bits(mc_cfg_t) +: $bits(mc_cfg_t)]);

    sop_macrocell u_mc (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sum_i    (sum[o]),
      .reg_sel_i(mc_cfg[o].reg_sel),
      .oe_cfg_i (mc_cfg[o].oe),
      .load_i   (cfg_en_i),
      .out_o    (out_o[o]),
      .oe_o     (oe_o[o]),
      .fb_o     (fb[o])
    );

    // R8
    fb_lit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (lit[2*(N_IN+o)] == $past(sum[o])) &&
               (lit[2*(N_IN+o)+1] != lit[2*(N_IN+o)]));
  end

  // R7
  oe_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |-> (oe_o == '0));
  // R9
  rst_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (cfg == '0) && (oe_o == '0));
endmodule

// File: tb/sop_array_bench.sv
module sop_array_bench;
  localparam int CLK_P = 10;
  localparam int N_IN = 4, N_PT = 8, N_OUT = 2;
  localparam int N_LIT = 2 * (N_IN + N_OUT);
  localparam int AND_W = N_PT * N_LIT;
  localparam int OR_W  = N_OUT * N_PT;
  localparam int MC_B  = AND_W + OR_W;
  localparam int CFG_W = MC_B + 2 * N_OUT;
  localparam int GRP   = N_PT / N_OUT;

  logic clk = 1'b0, rst_n = 1'b0, cfg_en = 1'b0, cfg_bit = 1'b0, mode = 1'b0;
  logic [N_IN-1:0]  in_v = '0;
  logic [N_OUT-1:0] out, oe;

  int checks = 0, errors = 0;
  logic [CFG_W-1:0] img, cfg_m;
  logic [N_OUT-1:0] fb_m;

  always #(CLK_P/2) clk = ~clk;

  sop_array u_sop_array (
    .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(cfg_en), .cfg_bit_i(cfg_bit),
    .pal_mode_i(mode), .in_i(in_v), .out_o(out), .oe_o(oe)
  );

  function automatic logic m_sum(int o);
    logic s = 1'b0;
    for (int p = 0; p < N_PT; p++) begin
      logic used = mode ? ((p / GRP) == o) : cfg_m[AND_W + o*N_PT + p];
      logic any = 1'b0, val = 1'b1;
      for (int l = 0; l < N_LIT; l++) begin
        if (cfg_m[p*N_LIT + l]) begin
          int k = l / 2;
          logic sv = (k < N_IN) ? in_v[k] : fb_m[k - N_IN];
          any = 1'b1;
          if ((l % 2) == 1) sv = ~sv;
          if (!sv) val = 1'b0;
        end
      end
      if (used && any && val) s = 1'b1;
    end
    return s;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_m = '0;
      fb_m  = '0;
    end else begin
      logic [N_OUT-1:0] ns;
      for (int o = 0; o < N_OUT; o++) ns[o] = m_sum(o);
      if (cfg_en) cfg_m = {cfg_m[CFG_W-2:0], cfg_bit};
      fb_m = ns;
    end
  end

  task automatic chk(string tag, logic [N_OUT-1:0] act, logic [N_OUT-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(string tag);
    logic [N_OUT-1:0] eo, ee;
    @(negedge clk);
    for (int o = 0; o < N_OUT; o++) begin
      logic s = m_sum(o);
      eo[o] = cfg_m[MC_B + 2*o] ? fb_m[o] : s;
      ee[o] = cfg_m[MC_B + 2*o + 1] & ~cfg_en;
    end
    chk(tag, out, eo);
    chk("R7", oe, ee);
  endtask

  task automatic set_and(int p, int l);
    img[p*N_LIT + l] = 1'b1;
  endtask

  task automatic set_or(int o, int p);
    img[AND_W + o*N_PT + p] = 1'b1;
  endtask

  task automatic set_mc(int o, logic rs, logic en);
    img[MC_B + 2*o]     = rs;
    img[MC_B + 2*o + 1] = en;
  endtask

  task automatic load();
    cfg_en = 1'b1;
    for (int i = CFG_W - 1; i >= 0; i--) begin
      cfg_bit = img[i];
      step("R1");
      chk("R7", oe, '0);
    end
    cfg_en  = 1'b0;
    cfg_bit = 1'b0;
  endtask

  task automatic sweep(string tag);
    for (int v = 0; v < 16; v++) begin
      in_v = v[N_IN-1:0];
      step(tag);
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", out, '0);
    chk("R9", oe, '0);
    rst_n = 1'b1;
    step("R9");

    // image A: PLA links, mixed polarities, feedback terms, one empty linked term
    img = '0;
    set_and(0, 0); set_and(0, 3);
    set_and(1, 4); set_and(1, 6);
    set_and(2, 8);
    set_and(3, 1); set_and(3, 11);
    set_or(0, 0); set_or(0, 1); set_or(0, 4);
    set_or(1, 2); set_or(1, 3);
    set_mc(0, 1'b1, 1'b1);
    set_mc(1, 1'b0, 1'b1);
    load();
    sweep("R4");
    sweep("R8");

    // R6: in0=1,in1=0 gives term0 -> out0 registered one cycle later
    in_v = 4'b0001;
    step("R6");
    chk("R6", out[0], 1'b1);
    in_v = 4'b0000;
    step("R6");
    chk("R6", out[0], 1'b0);

    // R2: toggling serial data without enable changes nothing
    for (int i = 0; i < 20; i++) begin
      cfg_bit = i[0];
      in_v = 4'($urandom);
      step("R2");
    end
    cfg_bit = 1'b0;

    // R5: fixed groups; out1 covers empty terms 4..7, so it stays 0
    mode = 1'b1;
    for (int v = 0; v < 16; v++) begin
      in_v = v[N_IN-1:0];
      step("R5");
      chk("R5", out[1], 1'b0);
    end
    mode = 1'b0;

    // image B: both outputs combinational, out1 disabled, no link on out1
    img = '0;
    set_and(4, 2); set_and(4, 5);
    set_and(5, 9); set_and(5, 7);
    set_and(6, 10);
    set_or(0, 4); set_or(0, 5); set_or(0, 6);
    set_mc(0, 1'b0, 1'b1);
    set_mc(1, 1'b0, 1'b0);
    load();
    sweep("R3");
    for (int i = 0; i < 12; i++) begin
      in_v = 4'($urandom);
      step("R4");
      chk("R4", out[1], 1'b0);
    end
    mode = 1'b1;
    sweep("R5");
    mode = 1'b0;

    // R9: asynchronous reset mid-run
    rst_n = 1'b0;
    #1;
    chk("R9", out, '0);
    chk("R9", oe, '0);
    step("R9");
    rst_n = 1'b1;
    sweep("R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule